// File: doc/BRIEF.md
# Power-Down Clock Gate

This block sits between a set of free-running clock sources and the pins that carry them. It stops every output cleanly when an active-low power-down pin is pulled low, and it restarts them cleanly when the pin is released. There are eight outputs: a differential CPU pair, a 66 MHz clock, a 48 MHz clock, a 33 MHz clock, a reference clock and a differential 100 MHz pair. Each output is treated as its own clock domain. The block also drives an output-enable for each CPU leg and a flag that powers down the PLL and VCO.

The power-down pin is qualified in the CPU complement clock domain. A qualified request is passed to every output domain through that domain's own synchronizer. Each output then stops only at its own falling edge, so no shortened pulse can reach a pin. The CPU pair parks in a special state: the true leg is held high, and the complement leg has its enable withdrawn so that the pad floats.

On release, the PLL flag drops first. The outputs come back after a programmable settling count of CPU clock cycles. Each output restarts at its next rising edge, with a full-width first pulse.

Top module: `pd_clock_gate`

## Requirements
- R1: The power-down pin passes through a chain of SYNC_STAGES (default 2) flops clocked on the rising edge of the CPU complement clock before it has any effect. pll_pd is still 0 about 25 ns after the pin falls.
- R2: A request is accepted only after the synchronized pin has been low on two consecutive rising edges of the CPU complement clock. On acceptance, pll_pd goes to 1.
- R3: Every non-CPU output is gated only while its own source clock is low. Every high pulse on these outputs, and on the CPU complement output, lasts exactly half the source period.
- R4: While the block is parked, the CPU true output is held at logic 1. The CPU true output-enable stays at 1 at all times.
- R5: The CPU complement output-enable is 1 while the outputs run and 0 while they are parked. 1 means the pin is driven.
- R6: While power-down is in effect, pll_pd is 1 and the six non-CPU outputs are held at 0.
- R7: The reference output carries REF_EXTRA additional synchronizer stages. It may therefore take several of its own cycles longer than the other outputs to park.
- R8: When the pin returns high, pll_pd falls while all outputs are still parked. The outputs resume SETTLE_CYC CPU cycles later, and the complement output-enable returns to 1.
- R9: After reset, all outputs toggle, pll_pd is 0 and both CPU output-enables are 1.
- R10: A low pulse on the power-down pin that is seen by only one rising edge of the CPU complement clock is ignored. pll_pd stays 0 and no output stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, applied in every clock domain |
| clk_cpu_t | input | 1 | CPU clock, true leg |
| clk_cpu_c | input | 1 | CPU clock, complement leg; the control domain |
| clk_3v66 | input | 1 | 66 MHz source clock |
| clk_usb | input | 1 | 48 MHz source clock |
| clk_pci | input | 1 | 33 MHz source clock |
| clk_ref | input | 1 | Reference source clock |
| clk_src_t | input | 1 | 100 MHz pair, true leg |
| clk_src_c | input | 1 | 100 MHz pair, complement leg |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| out_3v66 | output | 1 | Gated 66 MHz clock |
| out_usb | output | 1 | Gated 48 MHz clock |
| out_pci | output | 1 | Gated 33 MHz clock |
| out_ref | output | 1 | Gated reference clock |
| out_src_t | output | 1 | Gated 100 MHz true leg |
| out_src_c | output | 1 | Gated 100 MHz complement leg |
| out_cpu_t | output | 1 | Gated CPU true leg, parks high |
| out_cpu_c | output | 1 | Gated CPU complement leg |
| oe_cpu_t | output | 1 | Drive enable for the CPU true pad |
| oe_cpu_c | output | 1 | Drive enable for the CPU complement pad |
| pll_pd | output | 1 | Power-down flag for the PLL and VCO |

## Verification
The assertions assume the following about the inputs:
- Once a request has been accepted, the power-down pin stays low until the parked state is reached.
- After release, the pin stays high until the complement output-enable has returned to 1.
- Reset is held across several cycles of the slowest clock.

The stimulus keeps to these assumptions in three ways:
- It changes the pin 2 ns after a CPU complement rising edge, so the pin is never sampled on the edge itself.
- It holds each level for at least a microsecond, except for the deliberate single-edge glitch.
- It keeps reset high for 200 ns while all clocks run.

// File: rtl/pd_pkg.sv
package pd_pkg;
  // Control state in the CPU complement domain
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } pd_state_e;

  // Order of the non-CPU clocks inside the packed vectors of the top module
  localparam int NUM_AUX = 6;
  localparam int IDX_REF = 3;

  // Synchronizer depth for one non-CPU leg
  function automatic int leg_depth(input int idx, input int base, input int ref_extra);
    return (idx == IDX_REF) ? base + ref_extra : base;
  endfunction
endpackage

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrdn_n,
  output logic stop_req,
  output logic pll_pd
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);

  logic [SYNC_STAGES-1:0] pin_sh;
  logic                   pin_now;
  logic                   pin_prev;
  logic                   qual_low;
  pd_state_e              state;
  pd_state_e              state_nx;
  logic [CW-1:0]          cnt;
  logic                   settle_done;

  // Metastability chain for the asynchronous pin, idle value high
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sh   <= '1;
      pin_prev <= 1'b1;
    end else begin
      pin_sh   <= {pin_sh[SYNC_STAGES-2:0], pwrdn_n};
      pin_prev <= pin_now;
    end
  end

  assign pin_now     = pin_sh[SYNC_STAGES-1];
  assign qual_low    = !pin_now && !pin_prev;
  assign settle_done = (cnt == CW'(SETTLE_CYC - 1));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:    if (qual_low) state_nx = ST_STOP;
      ST_STOP:   if (pin_now) state_nx = ST_SETTLE;
      ST_SETTLE: begin
        if (qual_low)         state_nx = ST_STOP;
        else if (settle_done) state_nx = ST_RUN;
      end
      default:   state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      cnt      <= '0;
      pll_pd   <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      state    <= state_nx;
      cnt      <= (state == ST_SETTLE && state_nx == ST_SETTLE) ? cnt + 1'b1 : '0;
      pll_pd   <= (state_nx == ST_STOP);
      stop_req <= (state_nx != ST_RUN);
    end
  end
endmodule

// File: rtl/pd_leg.sv
module pd_leg #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  output logic run_en
);
  logic [STAGES-1:0] req_sh;

  // Carry the stop request into this leg's domain
  always_ff @(posedge clk) begin
    if (rst) req_sh <= '0;
    else     req_sh <= {req_sh[STAGES-2:0], stop_req};
  end

  // Enable moves only at a falling edge, while the source is low
  always_ff @(negedge clk) begin
    if (rst) run_en <= 1'b1;
    else     run_en <= ~req_sh[STAGES-1];
  end
endmodule

// File: rtl/pd_clock_gate.sv
module pd_clock_gate
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 16,
  parameter int REF_EXTRA   = 2
) (
  input  logic rst,
  input  logic clk_cpu_t,
  input  logic clk_cpu_c,
  input  logic clk_3v66,
  input  logic clk_usb,
  input  logic clk_pci,
  input  logic clk_ref,
  input  logic clk_src_t,
  input  logic clk_src_c,
  input  logic pwrdn_n,
  output logic out_3v66,
  output logic out_usb,
  output logic out_pci,
  output logic out_ref,
  output logic out_src_t,
  output logic out_src_c,
  output logic out_cpu_t,
  output logic out_cpu_c,
  output logic oe_cpu_t,
  output logic oe_cpu_c,
  output logic pll_pd
);
  localparam int NAUX = NUM_AUX;

  logic            stop_req;
  logic            cpu_en;
  logic [NAUX-1:0] aux_clk;
  logic [NAUX-1:0] aux_en;
  logic [NAUX-1:0] aux_out;

  pd_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_ctrl (
    .clk     (clk_cpu_c),
    .rst     (rst),
    .pwrdn_n (pwrdn_n),
    .stop_req(stop_req),
    .pll_pd  (pll_pd)
  );

  assign aux_clk = {clk_src_c, clk_src_t, clk_ref, clk_pci, clk_usb, clk_3v66};

  for (genvar g = 0; g < NAUX; g++) begin : g_aux
    pd_leg #(
      .STAGES(leg_depth(g, SYNC_STAGES, REF_EXTRA))
    ) u_leg (
      .clk     (aux_clk[g]),
      .rst     (rst),
      .stop_req(stop_req),
      .run_en  (aux_en[g])
    );
  end

  assign aux_out = aux_clk & aux_en;
  assign {out_src_c, out_src_t, out_ref, out_pci, out_usb, out_3v66} = aux_out;

  // CPU pair: enable moves on the complement falling edge, when the true leg rises
  pd_leg #(
    .STAGES(SYNC_STAGES)
  ) u_cpu_leg (
    .clk     (clk_cpu_c),
    .rst     (rst),
    .stop_req(stop_req),
    .run_en  (cpu_en)
  );

  assign out_cpu_t = clk_cpu_t | ~cpu_en;
  assign out_cpu_c = clk_cpu_c & cpu_en;
  assign oe_cpu_t  = 1'b1;
  assign oe_cpu_c  = cpu_en;
endmodule

// File: rtl/pd_clock_gate_chk.sv
module pd_clock_gate_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk_cpu_c,
  input logic rst,
  input logic pwrdn_n,
  input logic pll_pd,
  input logic oe_cpu_c
);
  localparam int HD = SYNC_STAGES + 2;

  logic [HD-1:0] pin_hist;

  always_ff @(posedge clk_cpu_c) begin
    if (rst) pin_hist <= '1;
    else     pin_hist <= {pin_hist[HD-2:0], pwrdn_n};
  end

  // R2
  qual_two_edges_chk: assert property (@(posedge clk_cpu_c) disable iff (rst)
    $rose(pll_pd) |-> (!pin_hist[SYNC_STAGES] && !pin_hist[SYNC_STAGES+1]));

  // R8
  pd_release_chk: assert property (@(posedge clk_cpu_c) disable iff (rst)
    $fell(pll_pd) |-> pin_hist[SYNC_STAGES]);

  // R8
  resume_pll_up_chk: assert property (@(posedge clk_cpu_c) disable iff (rst)
    $rose(oe_cpu_c) |-> !pll_pd);

  // R9
  reset_state_chk: assert property (@(posedge clk_cpu_c) disable iff (rst)
    $fell(rst) |-> (oe_cpu_c && !pll_pd));
endmodule

bind pd_clock_gate pd_clock_gate_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_cpu_c(clk_cpu_c),
  .rst      (rst),
  .pwrdn_n  (pwrdn_n),
  .pll_pd   (pll_pd),
  .oe_cpu_c (oe_cpu_c)
);

// File: tb/sim_pd_clock_gate.sv
`timescale 1ns/1ps
module sim_pd_clock_gate;
  logic rst = 1'b1;
  logic pwrdn_n = 1'b1;
  logic clk_cpu_t = 1'b0, clk_cpu_c = 1'b1;
  logic clk_3v66 = 1'b0, clk_usb = 1'b0, clk_pci = 1'b0, clk_ref = 1'b0;
  logic clk_src_t = 1'b0, clk_src_c = 1'b1;
  logic out_3v66, out_usb, out_pci, out_ref, out_src_t, out_src_c;
  logic out_cpu_t, out_cpu_c, oe_cpu_t, oe_cpu_c, pll_pd;
  logic [7:0] gout;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  pd_clock_gate u0 (.*);

  assign gout = {out_cpu_c, out_cpu_t, out_src_c, out_src_t, out_ref, out_pci, out_usb, out_3v66};

  // CPU pair at 100 MHz, other sources at their own rates
  initial forever begin #5;    clk_cpu_t = ~clk_cpu_t; clk_cpu_c = ~clk_cpu_t; end
  initial forever begin #7.5;  clk_3v66 = ~clk_3v66; end
  initial forever begin #10.5; clk_usb  = ~clk_usb;  end
  initial forever begin #15;   clk_pci  = ~clk_pci;  end
  initial forever begin #35;   clk_ref  = ~clk_ref;  end
  initial begin #2; forever begin clk_src_t = ~clk_src_t; clk_src_c = ~clk_src_t; #5; end end

  typedef struct {
    string      tag;
    int         win;
    logic [7:0] act_exp;
    logic [7:0] act_care;
    logic [9:0] lv_exp;
    logic [9:0] lv_care;
  } exp_t;

  exp_t sb_q[$];

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  // Driver side: queue an expectation and let the monitor observe its window
  task automatic expect_item(input string tag, input int win, input logic [7:0] ae,
                             input logic [7:0] ac, input logic [9:0] le, input logic [9:0] lc);
    exp_t it;
    it.tag = tag; it.win = win;
    it.act_exp = ae; it.act_care = ac; it.lv_exp = le; it.lv_care = lc;
    sb_q.push_back(it);
    #(win + 1);
  endtask

  // Monitor: pop expectations, watch activity over the window, compare
  exp_t       mon_it;
  logic [7:0] mon_prev, mon_act;
  logic [9:0] mon_lv;
  initial forever begin
    wait (sb_q.size() != 0);
    mon_it = sb_q.pop_front();
    mon_prev = gout;
    mon_act = '0;
    for (int s = 0; s < mon_it.win * 2; s++) begin
      #0.5;
      mon_act |= gout ^ mon_prev;
      mon_prev = gout;
    end
    mon_lv = {oe_cpu_c, pll_pd, gout};
    for (int b = 0; b < 8; b++)
      if (mon_it.act_care[b]) chk(mon_it.tag, $sformatf("activity[%0d]", b), mon_act[b], mon_it.act_exp[b]);
    for (int b = 0; b < 10; b++)
      if (mon_it.lv_care[b]) chk(mon_it.tag, $sformatf("level[%0d]", b), mon_lv[b], mon_it.lv_exp[b]);
  end

  // R3: pulse-width watcher on every output except the CPU true leg
  int hl [8] = '{-1, -1, -1, -1, -1, -1, -1, -1};
  int half2 [8] = '{15, 21, 30, 70, 10, 10, 0, 10};
  int runt_cnt = 0, pulse_cnt = 0;
  initial begin
    #0.25;
    forever begin
      #0.5;
      if (!rst) begin
        for (int i = 0; i < 8; i++) begin
          if (i != 6) begin
            if (gout[i] === 1'b1) begin
              if (hl[i] >= 0) hl[i]++;
            end else begin
              if (hl[i] > 0) begin
                pulse_cnt++;
                if (hl[i] < half2[i] - 1 || hl[i] > half2[i] + 1) begin
                  runt_cnt++;
                  if (runt_cnt < 5)
                    $display("FAIL R3 pulse on output %0d: got %0d half-ns expected %0d", i, hl[i], half2[i]);
                end
              end
              hl[i] = 0;
            end
          end
        end
      end
    end
  end

  task automatic finish_run();
    n_chk++;
    if (runt_cnt != 0 || pulse_cnt == 0) begin
      n_fail++;
      $display("FAIL R3 runt pulses: got %0d of %0d expected 0", runt_cnt, pulse_cnt);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  localparam logic [9:0] LV_RUN  = 10'b10_0000_0000;
  localparam logic [9:0] LV_PARK = 10'b01_0100_0000;

  initial begin
    #203.3;
    rst = 1'b0;
    #100;
    // R9: running after reset, enables asserted
    expect_item("R9", 300, 8'hFF, 8'hFF, LV_RUN, 10'b11_0000_0000);
    n_chk++;
    if (oe_cpu_t !== 1'b1) begin n_fail++; $display("FAIL R4 oe_cpu_t: got %b expected 1", oe_cpu_t); end

    // R10: glitch caught by a single complement rising edge
    @(posedge clk_cpu_c); #2; pwrdn_n = 1'b0; #9; pwrdn_n = 1'b1;
    #100;
    expect_item("R10", 300, 8'hFF, 8'hFF, LV_RUN, 10'b11_0000_0000);

    // R1 and R2: synchronizer latency, then acceptance
    @(posedge clk_cpu_c); #2; pwrdn_n = 1'b0;
    #25;
    expect_item("R1", 0, 8'h00, 8'h00, 10'b00_0000_0000, 10'b01_0000_0000);
    #19;
    expect_item("R2", 0, 8'h00, 8'h00, 10'b01_0000_0000, 10'b01_0000_0000);

    // R4 R5 R6 R7: parked state, with REF given a long settle
    #2000;
    expect_item("R4 R5 R6 R7", 300, 8'h00, 8'hFF, LV_PARK, 10'h3FF);

    // R8: release, PLL flag first, outputs still parked
    @(posedge clk_cpu_c); #2; pwrdn_n = 1'b1;
    #28;
    expect_item("R8", 30, 8'h00, 8'hFF, 10'b00_0000_0000, 10'b01_0000_0000);
    #1500;
    expect_item("R8", 300, 8'hFF, 8'hFF, LV_RUN, 10'b11_0000_0000);

    // Second cycle to exercise the gate again
    @(posedge clk_cpu_c); #2; pwrdn_n = 1'b0;
    #2000;
    expect_item("R6", 300, 8'h00, 8'hFF, LV_PARK, 10'h3FF);
    @(posedge clk_cpu_c); #2; pwrdn_n = 1'b1;
    #1500;
    expect_item("R5 R8", 300, 8'hFF, 8'hFF, LV_RUN, 10'b11_0000_0000);

    done = 1;
    finish_run();
  end

  // Watchdog
  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule